// File: doc/BRIEF.md
# Hopping Binary-FSK Frequency Word Source

This block supplies the frequency control word that a downstream phase accumulator turns into a baseband tone. The word it presents places the tone at the current hop channel. It then shifts that tone up or down by a fixed deviation, according to the data bit being sent. The current channel is drawn pseudo-randomly from 58 channels spaced 40 kHz apart. A small maximal-length shift register generates the channel number. Any value outside the channel range is stepped past.

Two word lanes run in parallel. One holds the lower-tone words and the other holds the upper-tone words. Each lane is a constant table with one 20-bit entry per channel, and both lanes are indexed by the same channel number. On each strobe, the data bit picks which lane's word is registered onto the output.

Two strobes control the timing. A hop strobe moves to the next channel, and a symbol strobe re-samples the data bit. Both strobes run much slower than the accumulator clock, and two symbols are normally sent per hop. Between strobes the output word is held.

Top module: `fhfsk_fcw_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the channel becomes 0, the shift register is loaded with the seed (1), and after that edge `fcw` equals the channel-0 lower-tone word, 28026.
- R2: The word for channel k (0..57) and tone bit d is round((1180000 + 40000·k + (d ? +20000 : −20000)) · 2^20 / 43400000). For example, channel 0 with d=1 gives 28993.
- R3: The 6-bit shift register steps as s_next = {s[4:0], s[5]^s[4]}. At a hop strobe it steps once, and steps again while its value is 58 or more. The resulting value becomes the new channel. From reset, the first hop therefore selects channel 2, which gives a lower-tone word of 29959.
- R4: The channel number is always below 58, including across hops that skip out-of-range states.
- R5: If neither strobe is high at a rising edge, `fcw` does not change after that edge, whatever `data_bit` does.
- R6: A symbol strobe without a hop strobe loads `fcw`, after that edge, with the word for the current channel and the value of `data_bit` at the edge.
- R7: A hop strobe, with or without a symbol strobe, loads `fcw`, after that edge, with the word for the newly selected channel and the value of `data_bit` at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hop_stb | input | 1 | One-cycle pulse: advance to the next channel |
| sym_stb | input | 1 | One-cycle pulse: present the tone for `data_bit` |
| data_bit | input | 1 | Serial data bit; 1 selects the upper tone |
| fcw | output | 20 | Registered frequency control word |

## Verification
The bench runs hundreds of hops, so that the shift register passes its out-of-range states. A design that failed to skip those states, or skipped them only once, would drift from the model's channel sequence or emit a word past channel 57. The bench also fires hop and symbol strobes in the same cycle. A design that let the symbol path win would repeat the old channel's word. It toggles `data_bit` while no strobe is present, which catches any output that follows the data combinationally. Finally, it checks literal words for reset, the first hop and the upper tone. These catch an off-by-one in the channel base, in the rounding or in the tone sign.

// File: rtl/fhfsk_pkg.sv
package fhfsk_pkg;

  // Rounded control word for one channel and tone.
  function automatic longint tone_word(input longint ch, input bit up,
                                       input longint clk_hz, input longint base_hz,
                                       input longint spacing_hz, input longint dev_hz);
    longint f;
    f = base_hz + ch * spacing_hz + (up ? dev_hz : -dev_hz);
    return (f * 64'sd1048576 + clk_hz / 2) / clk_hz;
  endfunction

  // One Fibonacci step, shifting left, feedback from the tap mask.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s, input logic [15:0] taps,
                                            input int w);
    logic [15:0] m;
    m = (16'd1 << w) - 16'd1;
    return ((s << 1) | {15'd0, ^(s & taps)}) & m;
  endfunction

endpackage

// File: rtl/fhfsk_hop_seq.sv
module fhfsk_hop_seq #(
  parameter int LFSR_W    = 6,
  parameter int NUM_CH    = 58,
  parameter logic [LFSR_W-1:0] TAPS = 6'b110000,
  parameter logic [LFSR_W-1:0] SEED = 6'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hop_stb,
  output logic [LFSR_W-1:0] chan_q,
  output logic [LFSR_W-1:0] chan_sel,
  output logic [LFSR_W-1:0] lfsr_q
);
  localparam int MAX_TRY = (1 << LFSR_W) - NUM_CH + 1;
  localparam logic [LFSR_W-1:0] CH_LIM = LFSR_W'(NUM_CH);

  logic [LFSR_W-1:0] nxt;

  always_comb begin
    logic [LFSR_W-1:0] cand;
    logic              done;
    cand = lfsr_q;
    nxt  = lfsr_q;
    done = 1'b0;
    for (int i = 0; i < MAX_TRY; i++) begin
      cand = LFSR_W'(fhfsk_pkg::lfsr_step(16'(cand), 16'(TAPS), LFSR_W));
      if (!done && cand < CH_LIM) begin
        nxt  = cand;
        done = 1'b1;
      end
    end
  end

  assign chan_sel = hop_stb ? nxt : chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= SEED;
      chan_q <= '0;
    end else if (hop_stb) begin
      lfsr_q <= nxt;
      chan_q <= nxt;
    end
  end
endmodule

// File: rtl/fhfsk_tone_rom.sv
module fhfsk_tone_rom #(
  parameter int     FCW_W      = 20,
  parameter int     NUM_CH     = 58,
  parameter int     ADDR_W     = 6,
  parameter bit     TONE_UP    = 1'b0,
  parameter longint CLK_HZ     = 43_400_000,
  parameter longint BASE_HZ    = 1_180_000,
  parameter longint SPACING_HZ = 40_000,
  parameter longint DEV_HZ     = 20_000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [FCW_W-1:0]  word
);
  logic [FCW_W-1:0] rom [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_entry
    assign rom[c] = FCW_W'(fhfsk_pkg::tone_word(longint'(c), TONE_UP, CLK_HZ,
                                                BASE_HZ, SPACING_HZ, DEV_HZ));
  end

  assign word = rom[addr];
endmodule

// File: rtl/fhfsk_fcw_gen.sv
module fhfsk_fcw_gen #(
  parameter int     FCW_W      = 20,
  parameter int     NUM_CH     = 58,
  parameter int     LFSR_W     = 6,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 6'b110000,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 6'd1,
  parameter longint CLK_HZ     = 43_400_000,
  parameter longint BASE_HZ    = 1_180_000,
  parameter longint SPACING_HZ = 40_000,
  parameter longint DEV_HZ     = 20_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hop_stb,
  input  logic             sym_stb,
  input  logic             data_bit,
  output logic [FCW_W-1:0] fcw
);
  localparam logic [FCW_W-1:0] RST_WORD =
    FCW_W'(fhfsk_pkg::tone_word(0, 1'b0, CLK_HZ, BASE_HZ, SPACING_HZ, DEV_HZ));

  logic [LFSR_W-1:0] chan_q;
  logic [LFSR_W-1:0] chan_sel;
  logic [LFSR_W-1:0] lfsr_q;
  logic [FCW_W-1:0]  lane_word [2];

  fhfsk_hop_seq #(
    .LFSR_W(LFSR_W), .NUM_CH(NUM_CH), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_seq (
    .clk(clk), .rst(rst), .hop_stb(hop_stb),
    .chan_q(chan_q), .chan_sel(chan_sel), .lfsr_q(lfsr_q)
  );

  // Lane 0 holds lower-tone words, lane 1 upper-tone words.
  for (genvar t = 0; t < 2; t++) begin : g_lane
    fhfsk_tone_rom #(
      .FCW_W(FCW_W), .NUM_CH(NUM_CH), .ADDR_W(LFSR_W), .TONE_UP(t[0]),
      .CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ), .SPACING_HZ(SPACING_HZ), .DEV_HZ(DEV_HZ)
    ) u_rom (
      .addr(chan_sel), .word(lane_word[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fcw <= RST_WORD;
    else if (hop_stb || sym_stb) fcw <= lane_word[data_bit];
  end
endmodule

// File: rtl/fhfsk_fcw_chk.sv
module fhfsk_fcw_chk #(
  parameter int FCW_W  = 20,
  parameter int NUM_CH = 58,
  parameter int LFSR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              hop_stb,
  input logic              sym_stb,
  input logic [FCW_W-1:0]  fcw,
  input logic [LFSR_W-1:0] chan_q,
  input logic [LFSR_W-1:0] lfsr_q
);
  p_reset_chan_r1: assert property (@(posedge clk) rst |=> chan_q == '0);

  p_word_held_r5: assert property (@(posedge clk) disable iff (rst)
    (!hop_stb && !sym_stb) |=> $stable(fcw));

  p_chan_range_r4: assert property (@(posedge clk) disable iff (rst)
    chan_q < LFSR_W'(NUM_CH));

  p_chan_still_r3: assert property (@(posedge clk) disable iff (rst)
    !hop_stb |=> $stable(chan_q));

  p_chan_moves_r7: assert property (@(posedge clk) disable iff (rst)
    hop_stb |=> chan_q != $past(chan_q));

  p_lfsr_live_r3: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
endmodule

bind fhfsk_fcw_gen fhfsk_fcw_chk #(
  .FCW_W(FCW_W), .NUM_CH(NUM_CH), .LFSR_W(LFSR_W)
) u_chk (
  .clk(clk), .rst(rst), .hop_stb(hop_stb), .sym_stb(sym_stb),
  .fcw(fcw), .chan_q(chan_q), .lfsr_q(lfsr_q)
);

// File: tb/fhfsk_fcw_gen_bench.sv
module fhfsk_fcw_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hop_stb = 1'b0;
  logic sym_stb = 1'b0;
  logic data_bit = 1'b0;
  logic [19:0] fcw;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int    m_lfsr = 1;
  int    m_ch   = 0;
  int    m_word = 0;
  string m_tag  = "R1";

  always #10 clk = ~clk;

  fhfsk_fcw_gen u_fhfsk_fcw_gen (
    .clk(clk), .rst(rst), .hop_stb(hop_stb), .sym_stb(sym_stb),
    .data_bit(data_bit), .fcw(fcw)
  );

  function automatic int ref_word(int ch, int up);
    longint f;
    f = 64'd1180000 + longint'(ch) * 40000 + (up != 0 ? 20000 : -20000);
    return int'((f * 1048576 + 21700000) / 43400000);
  endfunction

  function automatic int ref_step(int s);
    int fb;
    fb = ((s >> 5) ^ (s >> 4)) & 1;
    return ((s << 1) & 63) | fb;
  endfunction

  // Behavioural reference, updated at each rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_lfsr = 1; m_ch = 0; m_word = ref_word(0, 0); m_tag = "R1";
    end else if (hop_stb) begin
      int hops;
      hops = 0;
      m_lfsr = ref_step(m_lfsr);
      while (m_lfsr >= 58) begin m_lfsr = ref_step(m_lfsr); hops++; end
      m_ch = m_lfsr;
      m_word = ref_word(m_ch, int'(data_bit));
      m_tag = (hops > 0) ? "R4" : "R7";
    end else if (sym_stb) begin
      m_word = ref_word(m_ch, int'(data_bit));
      m_tag = "R6";
    end else begin
      m_tag = "R5";
    end
  end

  task automatic check(string req, int exp);
    n_cmp++;
    if (int'(fcw) != exp) begin
      n_bad++;
      $display("FAIL %s: fcw actual %0d expected %0d at %0t", req, fcw, exp, $time);
    end
  endtask

  task automatic step(bit h, bit s, bit d);
    hop_stb = h; sym_stb = s; data_bit = d;
    @(negedge clk);
    check(m_tag, m_word);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R1", 28026);
    rst = 1'b0;
    step(1'b0, 1'b1, 1'b1);
    check("R2", 28993);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, i[0]);
    check("R5", 28993);
    step(1'b1, 1'b0, 1'b0);
    check("R3", 29959);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4000; i++)
      step(($urandom % 6) == 0, ($urandom % 3) == 0, $urandom % 2);
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1);
    rst = 1'b0;
    check("R1", 28026);
    for (int i = 0; i < 400; i++) step(1'b1, 1'b0, $urandom % 2);
    for (int i = 0; i < 1000; i++)
      step(($urandom % 4) == 0, ($urandom % 2) == 0, $urandom % 2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule